// File: doc/BRIEF.md
# OSD Character Grid Position Generator

This block follows the raster of an incoming video signal and says, for every dot clock, which cell of a small character overlay is under the beam. The overlay is a grid of 24 columns by 12 rows. Each cell is 12 dots wide and 18 scan lines tall. A dot counter restarts on each falling edge of the active-low horizontal sync. A line counter restarts on each falling edge of the active-low vertical sync and advances on every horizontal sync edge. The overlay window begins a programmable number of lines below vertical sync and a programmable number of dot clocks after horizontal sync.

Each character row can be switched to double size on its own. A double row repeats every dot for two clocks and every scan line for two lines. Its cells are therefore 24 dots wide and the row is 36 lines tall, and every row below it moves down. The outputs give the row, the column, the glyph scan line and the glyph dot, a cell-valid strobe, and the address for the character memory. A font lookup and the character memory downstream consume these values. All outputs are registered.

Top module: `osd_grid_pos`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, every output is 0.
- R2: A falling edge of `hsync_n` (high at one edge, low at the next) sets the dot count to 0 and adds one to the line count. A falling edge of `vsync_n` sets the line count to 0 and takes precedence over a horizontal edge on the same clock. Holding either sync low does not restart anything again.
- R3: Column 0, dot 0 is reported for the dot count equal to `hstart`. The outputs are registered, so with `hstart` = 0 the first valid cell appears on the second clock edge after the horizontal sync edge is sampled.
- R4: Row 0, line 0 is reported for the line count equal to `vstart`. Line `vstart` is the line that starts with the `vstart`-th horizontal sync edge after vertical sync.
- R5: In a normal-size row, with hx = dot count − `hstart` and vy the line offset in the row: `char_col` = hx/12, `glyph_dot` = hx mod 12, and `glyph_line` = vy (0..17).
- R6: When `dbl_rows[r]` is 1, row r is 36 lines tall and its cells are 24 dots wide. `glyph_line` = vy/2, `char_col` = hx/24 and `glyph_dot` = (hx mod 24)/2.
- R7: Each row begins at the sum of the heights (18 or 36) of the rows above it, so a double row pushes all later rows down.
- R8: `cell_valid` is 1 only inside the 24-column by 12-row window. When it is 0, the row, column, line, dot and address outputs are all 0.
- R9: When `disp_en` is 0, `cell_valid` is 0 on the next clock edge.
- R10: `vram_addr` = `char_row`·32 + `char_col`, with the row in bits [8:5] and the column in bits [4:0].
- R11: The dot count saturates at 2047 and the line count at 1023. A line with no horizontal sync edge does not make the window appear again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| vstart | input | 6 | Window top, in lines after vertical sync |
| hstart | input | 6 | Window left edge, in dot clocks after horizontal sync |
| disp_en | input | 1 | Overlay enable |
| dbl_rows | input | 12 | Double-size flag, one bit per character row |
| cell_valid | output | 1 | Beam is inside the character window |
| char_row | output | 4 | Character row 0..11 |
| char_col | output | 5 | Character column 0..23 |
| glyph_line | output | 5 | Scan line inside the glyph 0..17 |
| glyph_dot | output | 4 | Dot inside the glyph 0..11 |
| vram_addr | output | 9 | Character memory address {row, column} |

## Verification
Three rasters are applied. The first is a full frame with both offsets nonzero and all rows normal size. It separates the start offsets, the 12/18 cell division, the bottom and right window edges, and a two-line stretch with the display disabled. The second uses rows 0 and 2 at double size with zero offsets. It separates dot and line doubling from the downward shift of the rows that follow, and a spot check lands on row 1. The third is one line much longer than the dot counter's range, which tells a saturating counter apart from one that wraps and shows the window again.

// File: rtl/osd_grid_pkg.sv
package osd_grid_pkg;
  typedef struct packed {
    logic h_fall;
    logic v_fall;
  } sync_ev_t;
endpackage

// File: rtl/osd_sync_track.sv
module osd_sync_track
  import osd_grid_pkg::*;
#(
  parameter int DOT_W  = 11,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_n,
  input  logic              vsync_n,
  output logic [DOT_W-1:0]  dot_cnt,
  output logic [LINE_W-1:0] line_cnt
);
  localparam logic [DOT_W-1:0]  DOT_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic     hs_q, vs_q;
  sync_ev_t ev;

  always_comb begin
    ev.h_fall = hs_q & ~hsync_n;
    ev.v_fall = vs_q & ~vsync_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q     <= 1'b1;
      vs_q     <= 1'b1;
      dot_cnt  <= '0;
      line_cnt <= '0;
    end else begin
      hs_q <= hsync_n;
      vs_q <= vsync_n;
      if (ev.h_fall)
        dot_cnt <= '0;
      else if (dot_cnt != DOT_MAX)
        dot_cnt <= dot_cnt + 1'b1;
      if (ev.v_fall)
        line_cnt <= '0;
      else if (ev.h_fall && line_cnt != LINE_MAX)
        line_cnt <= line_cnt + 1'b1;
    end
  end

  // R2: a horizontal sync edge restarts the dot count
  p_dot_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (hs_q && !hsync_n) |=> (dot_cnt == '0));

  // R2: a vertical sync edge restarts the line count
  p_line_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (vs_q && !vsync_n) |=> (line_cnt == '0));

  // R11: with no sync edge the dot count stays at its ceiling
  p_dot_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (dot_cnt == DOT_MAX && hsync_n) |=> (dot_cnt == DOT_MAX));
endmodule

// File: rtl/osd_vmap.sv
module osd_vmap #(
  parameter int ROWS   = 12,
  parameter int CELL_H = 18,
  parameter int LINE_W = 10,
  parameter int POS_W  = 6,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int SUBY_W = $clog2(CELL_H)
) (
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [POS_W-1:0]  vstart,
  input  logic [ROWS-1:0]   dbl_rows,
  output logic              v_ok,
  output logic [ROW_W-1:0]  row_idx,
  output logic [SUBY_W-1:0] sub_line,
  output logic              row_dbl
);
  int vy, top, hgt, off;
  logic hit;

  always_comb begin
    vy       = int'(line_cnt) - int'(vstart);
    top      = 0;
    hgt      = 0;
    off      = 0;
    hit      = 1'b0;
    row_idx  = '0;
    row_dbl  = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      hgt = dbl_rows[r] ? 2 * CELL_H : CELL_H;
      if (!hit && vy >= top && vy < top + hgt) begin
        hit     = 1'b1;
        row_idx = ROW_W'(r);
        row_dbl = dbl_rows[r];
        off     = vy - top;
      end
      top = top + hgt;
    end
    v_ok     = hit;
    sub_line = SUBY_W'(row_dbl ? (off >> 1) : off);
  end
endmodule

// File: rtl/osd_hmap.sv
module osd_hmap #(
  parameter int COLS   = 24,
  parameter int CELL_W = 12,
  parameter int DOT_W  = 11,
  parameter int POS_W  = 6,
  localparam int COL_W  = $clog2(COLS),
  localparam int SUBX_W = $clog2(CELL_W)
) (
  input  logic [DOT_W-1:0]  dot_cnt,
  input  logic [POS_W-1:0]  hstart,
  input  logic              row_dbl,
  output logic              h_ok,
  output logic [COL_W-1:0]  col_idx,
  output logic [SUBX_W-1:0] sub_dot
);
  int hx, wid, left, off;
  logic hit;

  always_comb begin
    hx      = int'(dot_cnt) - int'(hstart);
    wid     = row_dbl ? 2 * CELL_W : CELL_W;
    left    = 0;
    off     = 0;
    hit     = 1'b0;
    col_idx = '0;
    for (int c = 0; c < COLS; c++) begin
      if (!hit && hx >= left && hx < left + wid) begin
        hit     = 1'b1;
        col_idx = COL_W'(c);
        off     = hx - left;
      end
      left = left + wid;
    end
    h_ok    = hit;
    sub_dot = SUBX_W'(row_dbl ? (off >> 1) : off);
  end
endmodule

// File: rtl/osd_grid_pos.sv
module osd_grid_pos #(
  parameter int COLS   = 24,
  parameter int ROWS   = 12,
  parameter int CELL_W = 12,
  parameter int CELL_H = 18,
  parameter int POS_W  = 6,
  parameter int DOT_W  = 11,
  parameter int LINE_W = 10,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int SUBX_W = $clog2(CELL_W),
  localparam int SUBY_W = $clog2(CELL_H)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hsync_n,
  input  logic                   vsync_n,
  input  logic [POS_W-1:0]       vstart,
  input  logic [POS_W-1:0]       hstart,
  input  logic                   disp_en,
  input  logic [ROWS-1:0]        dbl_rows,
  output logic                   cell_valid,
  output logic [ROW_W-1:0]       char_row,
  output logic [COL_W-1:0]       char_col,
  output logic [SUBY_W-1:0]      glyph_line,
  output logic [SUBX_W-1:0]      glyph_dot,
  output logic [ROW_W+COL_W-1:0] vram_addr
);
  logic [DOT_W-1:0]  dot_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic              v_ok, h_ok, row_dbl, hit;
  logic [ROW_W-1:0]  row_idx;
  logic [COL_W-1:0]  col_idx;
  logic [SUBY_W-1:0] sub_line;
  logic [SUBX_W-1:0] sub_dot;

  osd_sync_track #(.DOT_W(DOT_W), .LINE_W(LINE_W)) u_track (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .dot_cnt(dot_cnt), .line_cnt(line_cnt)
  );

  osd_vmap #(.ROWS(ROWS), .CELL_H(CELL_H), .LINE_W(LINE_W), .POS_W(POS_W)) u_vmap (
    .line_cnt(line_cnt), .vstart(vstart), .dbl_rows(dbl_rows),
    .v_ok(v_ok), .row_idx(row_idx), .sub_line(sub_line), .row_dbl(row_dbl)
  );

  osd_hmap #(.COLS(COLS), .CELL_W(CELL_W), .DOT_W(DOT_W), .POS_W(POS_W)) u_hmap (
    .dot_cnt(dot_cnt), .hstart(hstart), .row_dbl(row_dbl),
    .h_ok(h_ok), .col_idx(col_idx), .sub_dot(sub_dot)
  );

  assign hit = disp_en & v_ok & h_ok;

  always_ff @(posedge clk) begin
    if (rst || !hit) begin
      cell_valid <= 1'b0;
      char_row   <= '0;
      char_col   <= '0;
      glyph_line <= '0;
      glyph_dot  <= '0;
      vram_addr  <= '0;
    end else begin
      cell_valid <= 1'b1;
      char_row   <= row_idx;
      char_col   <= col_idx;
      glyph_line <= sub_line;
      glyph_dot  <= sub_dot;
      vram_addr  <= {row_idx, col_idx};
    end
  end

  // R9: a valid cell needs the enable on the previous edge
  p_enable_gate_r9: assert property (@(posedge clk) disable iff (rst)
    cell_valid |-> $past(disp_en));

  // R8: indices stay inside the grid
  p_grid_range_r8: assert property (@(posedge clk) disable iff (rst)
    cell_valid |-> (char_row < ROW_W'(ROWS) && char_col < COL_W'(COLS)));

  // R5: glyph coordinates stay inside one cell
  p_cell_range_r5: assert property (@(posedge clk) disable iff (rst)
    cell_valid |-> (glyph_dot < SUBX_W'(CELL_W) && glyph_line < SUBY_W'(CELL_H)));

  // R8: outside the window every index reads zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !cell_valid |-> (vram_addr == '0 && char_row == '0 && glyph_dot == '0 && glyph_line == '0));

  // R4: no cell above the programmed top line
  p_top_edge_r4: assert property (@(posedge clk) disable iff (rst)
    cell_valid |-> (int'($past(line_cnt)) >= int'($past(vstart))));

  // R3: no cell before the programmed left edge
  p_left_edge_r3: assert property (@(posedge clk) disable iff (rst)
    cell_valid |-> (int'($past(dot_cnt)) >= int'($past(hstart))));
endmodule

// File: tb/test_osd_grid_pos.sv
module test_osd_grid_pos;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsync_n = 1'b1, vsync_n = 1'b1, disp_en = 1'b0;
  logic [5:0] vstart = '0, hstart = '0;
  logic [11:0] dbl_rows = '0;
  logic       cell_valid;
  logic [3:0] char_row, glyph_dot;
  logic [4:0] char_col, glyph_line;
  logic [8:0] vram_addr;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  osd_grid_pos i_osd_grid_pos (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .vstart(vstart), .hstart(hstart), .disp_en(disp_en), .dbl_rows(dbl_rows),
    .cell_valid(cell_valid), .char_row(char_row), .char_col(char_col),
    .glyph_line(glyph_line), .glyph_dot(glyph_dot), .vram_addr(vram_addr)
  );

  // behavioural reference
  int m_dc, m_lc, vy, top, hgt, off, rr, wid, hx;
  bit m_hq, m_vq, hf, vf, hit, dbl;
  bit e_v; int e_row, e_col, e_line, e_dot;

  always @(posedge clk) begin
    if (rst) begin
      m_dc = 0; m_lc = 0; m_hq = 1; m_vq = 1;
      e_v = 0; e_row = 0; e_col = 0; e_line = 0; e_dot = 0;
    end else begin
      e_v = 0; e_row = 0; e_col = 0; e_line = 0; e_dot = 0;
      if (disp_en && m_lc >= vstart && m_dc >= hstart) begin
        vy = m_lc - vstart; top = 0; hit = 0; rr = 0; off = 0; dbl = 0;
        for (int r = 0; r < 12; r++) begin
          hgt = dbl_rows[r] ? 36 : 18;
          if (!hit && vy < top + hgt) begin
            hit = 1; rr = r; off = vy - top; dbl = dbl_rows[r];
          end
          top += hgt;
        end
        if (hit) begin
          wid = dbl ? 24 : 12;
          hx  = m_dc - hstart;
          if (hx < 24 * wid) begin
            e_v = 1; e_row = rr; e_col = hx / wid;
            e_dot = (hx % wid) / (dbl ? 2 : 1);
            e_line = off / (dbl ? 2 : 1);
          end
        end
      end
      hf = m_hq && !hsync_n;
      vf = m_vq && !vsync_n;
      if (vf) m_lc = 0; else if (hf && m_lc < 1023) m_lc++;
      if (hf) m_dc = 0; else if (m_dc < 2047) m_dc++;
      m_hq = hsync_n; m_vq = vsync_n;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (cell_valid !== e_v || char_row != e_row || char_col != e_col ||
          glyph_line != e_line || glyph_dot != e_dot || vram_addr != e_row * 32 + e_col) begin
        errors++;
        $display("FAIL %s t=%0t act v=%0d r=%0d c=%0d l=%0d d=%0d a=%0d exp v=%0d r=%0d c=%0d l=%0d d=%0d a=%0d",
          tag, $time, cell_valid, char_row, char_col, glyph_line, glyph_dot, vram_addr,
          e_v, e_row, e_col, e_line, e_dot, e_row * 32 + e_col);
      end
    end
  end

  task automatic spot(string req, bit v, int r, int c, int l, int d);
    checks++;
    if (cell_valid !== v || char_row != r || char_col != c || glyph_line != l || glyph_dot != d) begin
      errors++;
      $display("FAIL %s spot act v=%0d r=%0d c=%0d l=%0d d=%0d exp v=%0d r=%0d c=%0d l=%0d d=%0d",
        req, cell_valid, char_row, char_col, glyph_line, glyph_dot, v, r, c, l, d);
    end
  endtask

  // one raster line: sync low for 'low' cycles, optional vertical edge
  task automatic run_line(int period, int low, bit vfall);
    for (int i = 0; i < period; i++) begin
      @(negedge clk);
      hsync_n = (i >= low);
      vsync_n = !(vfall && i < low);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    spot("R1", 0, 0, 0, 0, 0);
    checks++;
    if (vram_addr != 0) begin errors++; $display("FAIL R1 addr act %0d exp 0", vram_addr); end
    rst = 1'b0;
    @(negedge clk);
    spot("R1", 0, 0, 0, 0, 0);
    cmp_on = 1'b1;

    // frame A: offsets nonzero, normal rows
    tag = "R2 R3 R4 R5 R8 R10";
    vstart = 6'd2; hstart = 6'd5; dbl_rows = '0; disp_en = 1'b1;
    run_line(310, 8, 1'b1);
    for (int ln = 1; ln < 222; ln++) begin
      if (ln == 50) begin tag = "R9"; disp_en = 1'b0; end
      if (ln == 52) begin tag = "R2 R3 R4 R5 R8 R10"; disp_en = 1'b1; end
      run_line(310, 8, 1'b0);
    end

    // frame B: rows 0 and 2 doubled, zero offsets
    tag = "R6 R7";
    vstart = 6'd0; hstart = 6'd0; dbl_rows = 12'b0000_0000_0101;
    run_line(600, 4, 1'b1);
    for (int ln = 1; ln < 110; ln++) begin
      if (ln == 40) begin
        // edge at i=0 sampled, dot 0 reported two edges later
        @(negedge clk); hsync_n = 1'b0;
        @(negedge clk); hsync_n = 1'b1;
        @(negedge clk);
        spot("R7", 1, 1, 0, 4, 0);
        run_line(597, 0, 1'b0);
      end else begin
        run_line(600, 4, 1'b0);
      end
    end

    // frame C: a line far longer than the dot counter range
    tag = "R11";
    dbl_rows = '0;
    run_line(2150, 4, 1'b1);
    spot("R11", 0, 0, 0, 0, 0);
    run_line(2300, 4, 1'b0);
    cmp_on = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule